// File: doc/BRIEF.md
# Code-Density Bin-by-Bin Calibrator

This block linearises the fine code of a tapped-delay-line time converter. The delay elements of such a line are uneven, so equal steps of the binary fine code do not stand for equal steps of time. The block measures the real width of every code bin with a code-density test. It feeds the ordinary hit stream into a histogram, with one counter per code, until a fixed number of hits has been counted. It then turns the histogram into a lookup table that gives, for every code, the time of the centre of its bin. Once the table is complete, every further hit is translated through it into a corrected fine time.

The three phases always run in this order: histogram, table build, measurement. A start pulse begins a calibration from the idle or measuring state. The state sequence is ST_IDLE, then ST_CLEAR (the histogram is zeroed, one bin per cycle), then ST_HIST (counting), then ST_DRAIN (the last count update lands), then ST_RDBIN, ST_LOAD, ST_DIVIDE and ST_STORE repeated once per bin, and finally ST_RUN. Each transition is named here with its condition:
- start_accept: ST_IDLE or ST_RUN to ST_CLEAR on a start pulse.
- clear_done: ST_CLEAR to ST_HIST after the last bin.
- quota_met: ST_HIST to ST_DRAIN on the final counted hit.
- drain_next: ST_DRAIN to ST_RDBIN.
- bin_loaded: ST_RDBIN to ST_LOAD, then ST_LOAD to ST_DIVIDE.
- quotient_ready: ST_DIVIDE to ST_STORE.
- next_bin: ST_STORE back to ST_RDBIN.
- table_done: ST_STORE to ST_RUN after the last bin.

Times are unsigned fixed-point integers, and the parameter `TCLK_UNITS` sets the sample-clock period in those units. The default is 45712, which is 2.857 ns in sixteenths of a picosecond. Entry k is written as floor((2·C_k + n_k)·TCLK_UNITS / (2·HIT_TOTAL)). Here n_k is the count of code k and C_k is the sum of the counts of all codes below k. This is the running width of the lower bins plus half the width of bin k.

Top module: `bin_density_calibrator`

## Requirements
- R1: While reset is asserted and directly after it, busy, table_ready, hit_dropped and time_valid are all low, and the block sits idle.
- R2: A start pulse seen in idle or in measurement raises busy and lowers table_ready on the next cycle. A start pulse while busy is ignored.
- R3: After a start, the histogram is cleared for exactly 2^CODE_W cycles. The following HIT_TOTAL valid hits are then each counted in the bin equal to their binary fine code. No count is lost when hits to the same code arrive back to back or one cycle apart.
- R4: The table entry for code k equals floor((2·C_k + n_k)·TCLK_UNITS / (2·HIT_TOTAL)), where n_k is the count of code k and C_k is the sum of the counts of codes 0..k−1 from the latest histogram.
- R5: In measurement, a valid hit produces time_valid exactly one cycle later, with time_out equal to the table entry of its code. No other cycle raises time_valid.
- R6: A valid hit during clearing, draining or table build has no effect on the histogram and raises hit_dropped for one cycle on the next cycle. No other hit raises hit_dropped.
- R7: Hits while idle, before any calibration, produce neither time_valid nor hit_dropped.
- R8: busy and table_ready are never high together. busy falls in the same cycle that table_ready rises. table_ready then stays high until a start pulse.
- R9: A recalibration started from measurement builds the new table from a freshly zeroed histogram, so no count from the previous run survives.
- R10: A corrected time never exceeds TCLK_UNITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | One-cycle request to begin a calibration |
| hit_valid | input | 1 | A fine code is present this cycle |
| hit_code | input | CODE_W | Binary fine code from the ones-counting encoder |
| busy | output | 1 | Calibration in progress (clear, histogram, drain, build) |
| table_ready | output | 1 | Table complete; measurement active |
| hit_dropped | output | 1 | Pulse: a hit arrived while it could neither be counted nor corrected |
| time_valid | output | 1 | Corrected time present |
| time_out | output | TIME_W | Corrected bin-centre time in TCLK_UNITS fixed-point |

## Verification
The bound checker watches the status and handshake relations on every cycle. These are: busy and ready are mutually exclusive, each corrected output comes from a valid hit one cycle earlier in measurement, each drop pulse comes from a hit that arrived while busy, the ready flag holds, a start from measurement is accepted, and the output stays in range. Only the bench's scenarios can show the numerical content of the table. They also show that back-to-back hits to one code are all counted, that the clear lasts exactly the stated number of cycles, and that a recalibration leaves no trace of the earlier histogram. The bench shows these by comparing every output against a behavioural model fed with skewed, bursty code patterns.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_CLEAR  = 4'd1,
        ST_HIST   = 4'd2,
        ST_DRAIN  = 4'd3,
        ST_RDBIN  = 4'd4,
        ST_LOAD   = 4'd5,
        ST_DIVIDE = 4'd6,
        ST_STORE  = 4'd7,
        ST_RUN    = 4'd8
    } cal_state_e;

endpackage

// File: rtl/cal_dpram.sv
module cal_dpram #(
    parameter int AW = 8,
    parameter int DW = 20
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // read returns the contents before a same-edge write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/cal_hist_update.sv
module cal_hist_update #(
    parameter int AW = 8,
    parameter int DW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic [AW-1:0] acc_code,
    input  logic [DW-1:0] rd_q,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    logic          stg_v;
    logic [AW-1:0] stg_code;
    logic          last_v;
    logic [AW-1:0] last_code;
    logic [DW-1:0] last_data;
    logic [DW-1:0] base;

    // the read for stg_code was taken at the edge the previous write landed,
    // so that write is invisible in rd_q and must be forwarded
    always_comb begin
        base = rd_q;
        if (last_v && (last_code == stg_code)) begin
            base = last_data;
        end
        wr_en   = stg_v;
        wr_addr = stg_code;
        wr_data = base + DW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v     <= 1'b0;
            stg_code  <= '0;
            last_v    <= 1'b0;
            last_code <= '0;
            last_data <= '0;
        end else begin
            stg_v     <= acc;
            stg_code  <= acc_code;
            last_v    <= stg_v;
            last_code <= stg_code;
            last_data <= wr_data;
        end
    end
endmodule

// File: rtl/cal_seq_divider.sv
module cal_seq_divider #(
    parameter int          NUM_W = 37,
    parameter int          DEN_W = 21,
    parameter int unsigned DENOM = 2048000,
    parameter int          Q_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] numer,
    output logic [Q_W-1:0]   quot,
    output logic             done
);
    localparam int CW = $clog2(NUM_W + 1);
    localparam logic [DEN_W:0] DEN_X = (DEN_W + 1)'(DENOM);

    logic [DEN_W-1:0] rem;
    logic [NUM_W-1:0] quo;
    logic [CW-1:0]    cnt;
    logic             run;
    logic [DEN_W:0]   trial;

    assign trial = {rem, quo[NUM_W-1]};
    assign quot  = quo[Q_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            quo  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else if (start) begin
            rem  <= '0;
            quo  <= numer;
            cnt  <= CW'(NUM_W);
            run  <= 1'b1;
            done <= 1'b0;
        end else if (run) begin
            if (trial >= DEN_X) begin
                rem <= DEN_W'(trial - DEN_X);
                quo <= {quo[NUM_W-2:0], 1'b1};
            end else begin
                rem <= trial[DEN_W-1:0];
                quo <= {quo[NUM_W-2:0], 1'b0};
            end
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
                run  <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/bin_density_calibrator.sv
module bin_density_calibrator
    import tdc_cal_pkg::*;
#(
    parameter int  CODE_W     = 8,
    parameter int  HIT_TOTAL  = 1024000,
    parameter int  TCLK_UNITS = 45712,
    localparam int TIME_W     = $clog2(TCLK_UNITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic              hit_valid,
    input  logic [CODE_W-1:0] hit_code,
    output logic              busy,
    output logic              table_ready,
    output logic              hit_dropped,
    output logic              time_valid,
    output logic [TIME_W-1:0] time_out
);
    localparam int BINS  = 1 << CODE_W;
    localparam int CNT_W = $clog2(HIT_TOTAL + 1);
    localparam int SUMW  = $clog2(2 * HIT_TOTAL + 1);
    localparam int NUM_W = SUMW + TIME_W;
    localparam logic [CODE_W-1:0] LAST_BIN = CODE_W'(BINS - 1);
    localparam logic [CNT_W-1:0]  LAST_HIT = CNT_W'(HIT_TOTAL - 1);

    cal_state_e state, state_nx;

    logic [CODE_W-1:0] idx;
    logic [CNT_W-1:0]  seen;
    logic [CNT_W-1:0]  cum;
    logic [CNT_W-1:0]  nk;
    logic              acc;

    // histogram memory signals
    logic              h_we, u_we;
    logic [CODE_W-1:0] h_waddr, u_waddr, h_raddr;
    logic [CNT_W-1:0]  h_wdata, u_wdata, h_q;
    logic              h_re;

    // table memory and divider signals
    logic [TIME_W-1:0] quot;
    logic              div_done;
    logic              div_go;
    logic [SUMW-1:0]   twice_sum;
    logic [NUM_W-1:0]  numer;
    logic              drop_now;

    assign acc = (state == ST_HIST) && hit_valid;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cal_start) state_nx = ST_CLEAR;
            ST_CLEAR:  if (idx == LAST_BIN) state_nx = ST_HIST;
            ST_HIST:   if (acc && (seen == LAST_HIT)) state_nx = ST_DRAIN;
            ST_DRAIN:  state_nx = ST_RDBIN;
            ST_RDBIN:  state_nx = ST_LOAD;
            ST_LOAD:   state_nx = ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_nx = ST_STORE;
            ST_STORE:  state_nx = (idx == LAST_BIN) ? ST_RUN : ST_RDBIN;
            ST_RUN:    if (cal_start) state_nx = ST_CLEAR;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // ---------------- walk counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            seen <= '0;
            cum  <= '0;
            nk   <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_RUN: if (cal_start) idx <= '0;
                ST_CLEAR: begin
                    idx  <= idx + CODE_W'(1);
                    seen <= '0;
                end
                ST_HIST:  if (acc) seen <= seen + CNT_W'(1);
                ST_DRAIN: begin
                    idx <= '0;
                    cum <= '0;
                end
                ST_LOAD:  nk <= h_q;
                ST_STORE: begin
                    cum <= cum + nk;
                    idx <= idx + CODE_W'(1);
                end
                default: ;
            endcase
        end
    end

    // ---------------- histogram ----------------
    cal_hist_update #(.AW(CODE_W), .DW(CNT_W)) u_upd (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .acc_code (hit_code),
        .rd_q     (h_q),
        .wr_en    (u_we),
        .wr_addr  (u_waddr),
        .wr_data  (u_wdata)
    );

    always_comb begin
        if (state == ST_CLEAR) begin
            h_we    = 1'b1;
            h_waddr = idx;
            h_wdata = '0;
        end else begin
            h_we    = u_we;
            h_waddr = u_waddr;
            h_wdata = u_wdata;
        end
        h_re    = acc || (state == ST_RDBIN);
        h_raddr = (state == ST_RDBIN) ? idx : hit_code;
    end

    cal_dpram #(.AW(CODE_W), .DW(CNT_W)) u_hist (
        .clk   (clk),
        .we    (h_we),
        .waddr (h_waddr),
        .wdata (h_wdata),
        .re    (h_re),
        .raddr (h_raddr),
        .rdata (h_q)
    );

    // ---------------- bin centre arithmetic ----------------
    assign twice_sum = SUMW'({cum, 1'b0}) + SUMW'(h_q);
    assign numer     = NUM_W'(twice_sum) * NUM_W'(TCLK_UNITS);
    assign div_go    = (state == ST_LOAD);

    cal_seq_divider #(
        .NUM_W (NUM_W),
        .DEN_W (SUMW),
        .DENOM (2 * HIT_TOTAL),
        .Q_W   (TIME_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_go),
        .numer (numer),
        .quot  (quot),
        .done  (div_done)
    );

    cal_dpram #(.AW(CODE_W), .DW(TIME_W)) u_lut (
        .clk   (clk),
        .we    (state == ST_STORE),
        .waddr (idx),
        .wdata (quot),
        .re    ((state == ST_RUN) && hit_valid),
        .raddr (hit_code),
        .rdata (time_out)
    );

    // ---------------- outputs ----------------
    assign drop_now = hit_valid && (state inside {ST_CLEAR, ST_DRAIN, ST_RDBIN,
                                                  ST_LOAD, ST_DIVIDE, ST_STORE});

    always_comb begin
        busy        = !(state inside {ST_IDLE, ST_RUN});
        table_ready = (state == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_valid  <= 1'b0;
            hit_dropped <= 1'b0;
        end else begin
            time_valid  <= (state == ST_RUN) && hit_valid;
            hit_dropped <= drop_now;
        end
    end
endmodule

// File: rtl/bin_density_calibrator_chk.sv
module bin_density_calibrator_chk #(
    parameter int TIME_W     = 16,
    parameter int TCLK_UNITS = 45712
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_start,
    input logic              hit_valid,
    input logic              busy,
    input logic              table_ready,
    input logic              hit_dropped,
    input logic              time_valid,
    input logic [TIME_W-1:0] time_out
);
    // R8
    busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && table_ready));

    // R5
    lookup_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && table_ready) |=> time_valid);

    // R5
    valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |-> $past(hit_valid && table_ready));

    // R6
    drop_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_dropped |-> $past(hit_valid && busy));

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (table_ready && !cal_start) |=> table_ready);

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (table_ready && cal_start) |=> (busy && !table_ready));

    // R10
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |-> (time_out <= TIME_W'(TCLK_UNITS)));
endmodule

bind bin_density_calibrator bin_density_calibrator_chk #(
    .TIME_W     (TIME_W),
    .TCLK_UNITS (TCLK_UNITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cal_start   (cal_start),
    .hit_valid   (hit_valid),
    .busy        (busy),
    .table_ready (table_ready),
    .hit_dropped (hit_dropped),
    .time_valid  (time_valid),
    .time_out    (time_out)
);

// File: tb/bin_density_calibrator_test.sv
module bin_density_calibrator_test;
    localparam int CODE_W = 8;
    localparam int BINS   = 1 << CODE_W;
    localparam int NHITS  = 600;
    localparam int TCLK   = 45712;
    localparam int TW     = $clog2(TCLK + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_start = 1'b0;
    logic hit_valid = 1'b0;
    logic [CODE_W-1:0] hit_code = '0;
    logic busy, table_ready, hit_dropped, time_valid;
    logic [TW-1:0] time_out;

    bin_density_calibrator #(
        .CODE_W(CODE_W), .HIT_TOTAL(NHITS), .TCLK_UNITS(TCLK)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .hit_valid(hit_valid), .hit_code(hit_code), .busy(busy),
        .table_ready(table_ready), .hit_dropped(hit_dropped),
        .time_valid(time_valid), .time_out(time_out)
    );

    always #4 clk = ~clk;  // 125 MHz

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    // behavioural model: 0 idle, 1 clearing, 2 counting, 3 building, 4 measuring
    int     ph = 0;
    int     clr_left = 0;
    int     seen = 0;
    int     hist [BINS];
    longint tbl [BINS];
    bit     exp_valid = 1'b0;
    bit     exp_drop = 1'b0;
    longint exp_time = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_table();
        longint cum = 0;
        for (int k = 0; k < BINS; k++) begin
            tbl[k] = ((2 * cum + hist[k]) * TCLK) / (2 * NHITS);
            cum += hist[k];
        end
    endtask

    task automatic step(input bit s, input bit h, input int c);
        @(negedge clk);
        chk(time_valid == exp_valid, "R5 time_valid", time_valid, exp_valid);
        if (exp_valid) chk(time_out == exp_time, "R4 table entry", time_out, exp_time);
        chk(hit_dropped == exp_drop, "R6/R7 hit_dropped", hit_dropped, exp_drop);
        if (ph == 3 && table_ready) begin
            ph = 4;
            chk(busy == 1'b0, "R8 busy falls with ready", busy, 0);
        end
        chk(busy == (ph >= 1 && ph <= 3), "R2 busy", busy, (ph >= 1 && ph <= 3));
        chk(table_ready == (ph == 4), "R8 table_ready", table_ready, (ph == 4));
        cal_start = s;
        hit_valid = h;
        hit_code  = CODE_W'(c);
        exp_valid = (ph == 4) && h;
        exp_time  = tbl[c];
        exp_drop  = h && (ph == 1 || ph == 3);
        case (ph)
            0, 4: if (s) begin
                ph = 1;
                clr_left = BINS;
                for (int k = 0; k < BINS; k++) hist[k] = 0;  // R9 fresh histogram
            end
            1: begin
                clr_left--;
                if (clr_left == 0) begin
                    ph = 2;
                    seen = 0;
                end
            end
            2: if (h) begin
                hist[c]++;
                seen++;
                if (seen == NHITS) begin
                    build_table();
                    ph = 3;
                end
            end
            default: ;
        endcase
    endtask

    function automatic int pat(input int i, input int seed);
        if ((i % 40) < 8) return 200 - seed;  // back-to-back bursts on one code (R3)
        if ((i % 97) == 13) return 0;
        if ((i % 89) == 7) return 255;
        return (i * 37 + seed * 11 + i / 3) % BINS;
    endfunction

    task automatic calibrate(input int seed);
        int i = 0;
        step(1'b1, 1'b0, 0);
        // clear: hits dropped, starts ignored (R6, R2)
        while (ph == 1) begin
            step(i % 50 == 5, (i % 3) == 0, (i * 7) % BINS);
            i++;
        end
        i = 0;
        // histogram with gaps and bursts (R3); stray starts ignored (R2)
        while (ph == 2) begin
            step(i == 100, (i % 9) != 4, pat(i, seed));
            i++;
        end
        i = 0;
        // build: hits dropped (R6)
        while (ph == 3 && i < 30000) begin
            step(i == 500, (i % 5) == 1, i % BINS);
            i++;
        end
        chk(ph == 4, "R8 table completes", ph, 4);
    endtask

    task automatic measure();
        for (int k = 0; k < BINS; k++) step(1'b0, 1'b1, k);         // R4 all codes, back to back
        for (int k = 0; k < 64; k++) step(1'b0, (k % 3) != 0, (k * 53) % BINS);  // R5 gaps
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < BINS; k++) begin
            hist[k] = 0;
            tbl[k] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy in reset", busy, 0);
        chk(table_ready == 0, "R1 ready in reset", table_ready, 0);
        chk(hit_dropped == 0, "R1 drop in reset", hit_dropped, 0);
        chk(time_valid == 0, "R1 valid in reset", time_valid, 0);
        rst_n = 1'b1;
        // R7 idle hits ignored
        for (int k = 0; k < 20; k++) step(1'b0, 1'b1, k * 13);
        calibrate(0);
        measure();
        // R9 recalibration with a different histogram
        calibrate(3);
        measure();
        step(1'b0, 1'b0, 0);
        step(1'b0, 1'b0, 0);
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule